// File: doc/BRIEF.md
# Range-Matched Software-Managed Translation Buffer

This block is a small, fully associative address translation buffer whose contents are managed entirely by software commands. Each slot describes one virtual page as an inclusive range, a begin address and an end address. It also holds a physical base address, a set of protection fields and a valid flag. A combinational lookup port reports whether an address falls inside any slot's range. On a hit it returns the index of that slot and the slot's contents.

Software builds a translation in two steps. The first is an address insert, which claims a slot, sets the range and the physical base, and leaves the slot invalid. The second is a protection insert, which fills in the permission fields and marks the slot valid. Two purge commands remove translations: one removes a single page, the other removes every slot. A removed slot is poisoned, with its begin address at all ones and everything else at zero, so it cannot match any later address. When an address insert finds no slot to reuse, it takes the slot at a round-robin victim pointer. Commands take effect at the clock edge. Lookups reflect the table as it stands.

Top module: `range_tlb`

## Requirements
- R1: A slot hits when its begin address is less than or equal to the lookup address and the lookup address is less than or equal to its end address, with both bounds inclusive. A slot hits whether or not it is valid. The lowest-indexed hitting slot is reported. `lk_valid` shows that slot's valid flag. With no hit, `lk_hit` is 0.
- R2: An address insert writes begin = address with the low 12 bits cleared, end = begin + 4095, and physical base = operand bits [24:5] shifted left by 12. The slot is left invalid.
- R3: When one or more slots cover the insert address, every covering slot that is valid is poisoned. The lowest-indexed covering slot is reused, and the victim pointer does not move.
- R4: When no slot covers the insert address, the slot at the victim pointer is poisoned and reused. The pointer then advances by one and wraps from 15 to 0.
- R5: A protection insert writes these fields from the operand into the slot hit by its address, then marks the slot valid: access id = bits [18:1], user = bit 19, second level = bits [21:20], first level = bits [23:22], type = bits [26:24], break = bit 27, dirty = bit 28, trap = bit 29. `lk_prot` returns the fields at those same bit positions, with all other bits 0.
- R6: A protection insert whose address hits no slot changes no slot. It drives `seq_err` high for exactly the one cycle after the command edge.
- R7: A poisoned slot has begin = all ones and all other fields 0, so it matches no address, including 0xFFFFFFFF and 0.
- R8: A single purge poisons the slot hit by its address only if that slot is valid. An invalid hit slot is left unchanged.
- R9: A full purge poisons every slot and leaves the victim pointer unchanged.
- R10: After reset, every slot is poisoned and the victim pointer is 0.
- R11: When several commands are raised in one cycle, only one takes effect. The order of precedence is full purge, then single purge, then address insert, then protection insert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_va | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Some slot's range covers `lk_va` |
| lk_idx | output | 4 | Index of the lowest hitting slot |
| lk_valid | output | 1 | Valid flag of the hitting slot |
| lk_beg | output | 32 | Begin address of the hitting slot (0 on miss) |
| lk_end | output | 32 | End address of the hitting slot (0 on miss) |
| lk_pa | output | 32 | Physical page base of the hitting slot (0 on miss) |
| lk_prot | output | 32 | Protection fields of the hitting slot, in the operand layout |
| cmd_purge_all | input | 1 | Poison every slot |
| cmd_purge_one | input | 1 | Poison the valid slot hit by `cmd_va` |
| cmd_ins_addr | input | 1 | Address insert at `cmd_va` |
| cmd_ins_prot | input | 1 | Protection insert at `cmd_va` |
| cmd_va | input | 32 | Command virtual address |
| cmd_op | input | 32 | Command operand word |
| seq_err | output | 1 | Protection insert missed, one-cycle pulse |

## Verification
The whole table is visible through the lookup port in the cycle right after any command edge. A wrongly written slot therefore appears at once as a wrong begin, end, base or protection word, or as a hit that should be a miss, when the affected page is probed.

A victim pointer that has gone wrong stays hidden until the next address insert that finds no covering slot. That insert lands at an unexpected index, or it evicts a page that should have survived. For this reason the tests fill the table until the pointer wraps, and they probe pages that should be evicted and pages that should survive.

A slot that is poisoned badly may stay hidden until an address near the all-ones or all-zeros boundary is probed. The tests probe both extremes after a reset and after a purge.

// File: rtl/rtlb_pkg.sv
package rtlb_pkg;
  parameter int VA_W    = 32;
  parameter int PA_W    = 32;
  parameter int OP_W    = 32;
  parameter int OFS_W   = 12;
  parameter int AID_W   = 18;
  parameter int PPN_LSB = 5;
  parameter int PPN_W   = PA_W - OFS_W;
  parameter int AID_LSB = 1;
  parameter int U_BIT   = 19;
  parameter int PL2_LSB = 20;
  parameter int PL1_LSB = 22;
  parameter int TYP_LSB = 24;
  parameter int B_BIT   = 27;
  parameter int D_BIT   = 28;
  parameter int T_BIT   = 29;

  typedef struct packed {
    logic [VA_W-1:0]  beg;
    logic [VA_W-1:0]  fin;
    logic [PA_W-1:0]  pa;
    logic [AID_W-1:0] aid;
    logic             usr;
    logic [1:0]       pl2;
    logic [1:0]       pl1;
    logic [2:0]       kind;
    logic             brk;
    logic             dirty;
    logic             trap;
    logic             vld;
  } rtlb_ent_t;

  function automatic logic [VA_W-1:0] page_first(input logic [VA_W-1:0] va);
    return {va[VA_W-1:OFS_W], {OFS_W{1'b0}}};
  endfunction

  function automatic logic [VA_W-1:0] page_last(input logic [VA_W-1:0] va);
    return {va[VA_W-1:OFS_W], {OFS_W{1'b1}}};
  endfunction

  function automatic logic [PA_W-1:0] op_to_pa(input logic [OP_W-1:0] op);
    return {op[PPN_LSB +: PPN_W], {OFS_W{1'b0}}};
  endfunction

  function automatic rtlb_ent_t poisoned();
    rtlb_ent_t e;
    e     = '0;
    e.beg = '1;
    return e;
  endfunction

  function automatic rtlb_ent_t apply_prot(input rtlb_ent_t e_in,
                                           input logic [OP_W-1:0] op);
    rtlb_ent_t e;
    e       = e_in;
    e.aid   = op[AID_LSB +: AID_W];
    e.usr   = op[U_BIT];
    e.pl2   = op[PL2_LSB +: 2];
    e.pl1   = op[PL1_LSB +: 2];
    e.kind  = op[TYP_LSB +: 3];
    e.brk   = op[B_BIT];
    e.dirty = op[D_BIT];
    e.trap  = op[T_BIT];
    e.vld   = 1'b1;
    return e;
  endfunction

  function automatic logic [OP_W-1:0] prot_word(input rtlb_ent_t e);
    logic [OP_W-1:0] w;
    w                   = '0;
    w[AID_LSB +: AID_W] = e.aid;
    w[U_BIT]            = e.usr;
    w[PL2_LSB +: 2]     = e.pl2;
    w[PL1_LSB +: 2]     = e.pl1;
    w[TYP_LSB +: 3]     = e.kind;
    w[B_BIT]            = e.brk;
    w[D_BIT]            = e.dirty;
    w[T_BIT]            = e.trap;
    return w;
  endfunction
endpackage

// File: rtl/rtlb_range_cmp.sv
module rtlb_range_cmp
  import rtlb_pkg::*;
#(
  parameter int N_ENT = 16
) (
  input  rtlb_ent_t [N_ENT-1:0] ents,
  input  logic [VA_W-1:0]       va,
  output logic [N_ENT-1:0]      hit_vec
);
  for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
    assign hit_vec[g] = (ents[g].beg <= va) && (va <= ents[g].fin);
  end
endmodule

// File: rtl/rtlb_first.sv
module rtlb_first #(
  parameter int N_ENT = 16,
  parameter int IDX_W = 4
) (
  input  logic [N_ENT-1:0] vec,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/range_tlb.sv
module range_tlb
  import rtlb_pkg::*;
#(
  parameter  int N_ENT = 16,
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VA_W-1:0]  lk_va,
  output logic             lk_hit,
  output logic [IDX_W-1:0] lk_idx,
  output logic             lk_valid,
  output logic [VA_W-1:0]  lk_beg,
  output logic [VA_W-1:0]  lk_end,
  output logic [PA_W-1:0]  lk_pa,
  output logic [OP_W-1:0]  lk_prot,
  input  logic             cmd_purge_all,
  input  logic             cmd_purge_one,
  input  logic             cmd_ins_addr,
  input  logic             cmd_ins_prot,
  input  logic [VA_W-1:0]  cmd_va,
  input  logic [OP_W-1:0]  cmd_op,
  output logic             seq_err
);
  rtlb_ent_t [N_ENT-1:0] tab_q, tab_d;
  logic [IDX_W-1:0]      vic_q, vic_d;
  logic                  seq_err_q;

  // lookup path
  logic [N_ENT-1:0] lk_vec;
  rtlb_ent_t        lk_ent;

  rtlb_range_cmp #(.N_ENT(N_ENT)) u_lk_cmp (
    .ents(tab_q), .va(lk_va), .hit_vec(lk_vec));
  rtlb_first #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_lk_first (
    .vec(lk_vec), .found(lk_hit), .idx(lk_idx));

  assign lk_ent   = lk_hit ? tab_q[lk_idx] : '0;
  assign lk_valid = lk_ent.vld;
  assign lk_beg   = lk_ent.beg;
  assign lk_end   = lk_ent.fin;
  assign lk_pa    = lk_ent.pa;
  assign lk_prot  = prot_word(lk_ent);

  // command path
  logic [N_ENT-1:0] cov_vec;
  logic             cmd_hit;
  logic [IDX_W-1:0] cmd_idx;

  rtlb_range_cmp #(.N_ENT(N_ENT)) u_cmd_cmp (
    .ents(tab_q), .va(cmd_va), .hit_vec(cov_vec));
  rtlb_first #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_cmd_first (
    .vec(cov_vec), .found(cmd_hit), .idx(cmd_idx));

  // named events, one per selected command
  logic             ev_purge_all, ev_purge_one, ev_ins_addr, ev_ins_prot;
  logic             ev_evict, ev_seq_err;
  logic [IDX_W-1:0] tgt_idx;
  logic [N_ENT-1:0] vld_vec;

  assign ev_purge_all = cmd_purge_all;
  assign ev_purge_one = !cmd_purge_all && cmd_purge_one;
  assign ev_ins_addr  = !cmd_purge_all && !cmd_purge_one && cmd_ins_addr;
  assign ev_ins_prot  = !cmd_purge_all && !cmd_purge_one && !cmd_ins_addr && cmd_ins_prot;
  assign ev_evict     = ev_ins_addr && !cmd_hit;
  assign ev_seq_err   = ev_ins_prot && !cmd_hit;
  assign tgt_idx      = ev_evict ? vic_q : cmd_idx;

  for (genvar g = 0; g < N_ENT; g++) begin : g_vld
    assign vld_vec[g] = tab_q[g].vld;
  end

  always_comb begin
    tab_d = tab_q;
    vic_d = vic_q;
    if (ev_purge_all) begin
      for (int i = 0; i < N_ENT; i++) tab_d[i] = poisoned();
    end else if (ev_purge_one) begin
      if (cmd_hit && tab_q[cmd_idx].vld) tab_d[cmd_idx] = poisoned();
    end else if (ev_ins_addr) begin
      for (int i = 0; i < N_ENT; i++) begin
        if (cov_vec[i] && tab_q[i].vld) tab_d[i] = poisoned();
      end
      if (ev_evict) begin
        tab_d[vic_q] = poisoned();
        vic_d = (vic_q == IDX_W'(N_ENT - 1)) ? '0 : vic_q + 1'b1;
      end
      tab_d[tgt_idx].beg = page_first(cmd_va);
      tab_d[tgt_idx].fin = page_last(cmd_va);
      tab_d[tgt_idx].pa  = op_to_pa(cmd_op);
    end else if (ev_ins_prot && cmd_hit) begin
      tab_d[cmd_idx] = apply_prot(tab_q[cmd_idx], cmd_op);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_ENT; i++) tab_q[i] <= poisoned();
      vic_q     <= '0;
      seq_err_q <= 1'b0;
    end else begin
      tab_q     <= tab_d;
      vic_q     <= vic_d;
      seq_err_q <= ev_seq_err;
    end
  end

  assign seq_err = seq_err_q;
endmodule

// File: rtl/range_tlb_chk.sv
module range_tlb_chk #(
  parameter int N_ENT = 16,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [31:0]      lk_va,
  input logic             lk_hit,
  input logic [31:0]      lk_beg,
  input logic [31:0]      lk_end,
  input logic             seq_err,
  input logic             ev_purge_all,
  input logic             ev_ins_addr,
  input logic             ev_ins_prot,
  input logic             ev_evict,
  input logic             cmd_hit,
  input logic [IDX_W-1:0] cmd_idx,
  input logic [IDX_W-1:0] tgt_idx,
  input logic [IDX_W-1:0] vic_q,
  input logic [N_ENT-1:0] vld_vec
);
  // R1
  hit_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_beg <= lk_va) && (lk_va <= lk_end));

  // R2
  ins_addr_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ins_addr |=> !vld_vec[$past(tgt_idx)]);

  // R3
  reuse_keeps_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ins_addr && cmd_hit) |=> $stable(vic_q));

  // R4
  victim_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_evict |=> vic_q == (($past(vic_q) == IDX_W'(N_ENT - 1)) ? '0 : $past(vic_q) + 1'b1));

  // R5
  prot_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ins_prot && cmd_hit) |=> vld_vec[$past(cmd_idx)]);

  // R6
  seq_err_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ins_prot && !cmd_hit) |=> seq_err);

  // R6
  seq_err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |-> $past(ev_ins_prot && !cmd_hit));

  // R9
  purge_all_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_purge_all |=> (vld_vec == '0) && !lk_hit);
endmodule

bind range_tlb range_tlb_chk #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_va(lk_va), .lk_hit(lk_hit),
  .lk_beg(lk_beg), .lk_end(lk_end), .seq_err(seq_err),
  .ev_purge_all(ev_purge_all), .ev_ins_addr(ev_ins_addr),
  .ev_ins_prot(ev_ins_prot), .ev_evict(ev_evict), .cmd_hit(cmd_hit),
  .cmd_idx(cmd_idx), .tgt_idx(tgt_idx), .vic_q(vic_q), .vld_vec(vld_vec));

// File: tb/range_tlb_tb.sv
module range_tlb_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lk_va = '0;
  logic        lk_hit, lk_valid, seq_err;
  logic [3:0]  lk_idx;
  logic [31:0] lk_beg, lk_end, lk_pa, lk_prot;
  logic        c_pa = 0, c_po = 0, c_ia = 0, c_ip = 0;
  logic [31:0] cmd_va = '0, cmd_op = '0;
  int          n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  range_tlb u_dut (
    .clk(clk), .rst_n(rst_n), .lk_va(lk_va), .lk_hit(lk_hit), .lk_idx(lk_idx),
    .lk_valid(lk_valid), .lk_beg(lk_beg), .lk_end(lk_end), .lk_pa(lk_pa),
    .lk_prot(lk_prot), .cmd_purge_all(c_pa), .cmd_purge_one(c_po),
    .cmd_ins_addr(c_ia), .cmd_ins_prot(c_ip), .cmd_va(cmd_va),
    .cmd_op(cmd_op), .seq_err(seq_err));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic look(input logic [31:0] va);
    lk_va = va;
    #1;
  endtask

  // expect a hit at idx with given valid and base
  task automatic look_hit(input string tag, input logic [31:0] va, input int idx,
                          input logic vld, input logic [31:0] pa);
    look(va);
    chk({tag, " hit"}, {31'd0, lk_hit}, 32'd1);
    chk({tag, " idx"}, {28'd0, lk_idx}, idx);
    chk({tag, " valid"}, {31'd0, lk_valid}, {31'd0, vld});
    chk({tag, " pa"}, lk_pa, pa);
  endtask

  task automatic look_miss(input string tag, input logic [31:0] va);
    look(va);
    chk({tag, " miss"}, {31'd0, lk_hit}, 32'd0);
  endtask

  task automatic cmd(input logic pa, input logic po, input logic ia, input logic ip,
                     input logic [31:0] va, input logic [31:0] op);
    @(negedge clk);
    c_pa = pa; c_po = po; c_ia = ia; c_ip = ip; cmd_va = va; cmd_op = op;
    @(negedge clk);
    c_pa = 0; c_po = 0; c_ia = 0; c_ip = 0;
  endtask

  task automatic t_reset();
    look_miss("R10 reset zero", 32'h0000_0000);
    look_miss("R7 reset top", 32'hFFFF_FFFF);
    look_miss("R10 reset mid", 32'h1234_5000);
    chk("R10 seq_err idle", {31'd0, seq_err}, 32'd0);
  endtask

  task automatic t_ins_addr();
    cmd(0, 0, 1, 0, 32'h1234_5678, 32'h0157_9BC0);
    look_hit("R2 page", 32'h1234_5000, 0, 1'b0, 32'hABCD_E000);
    chk("R2 begin", lk_beg, 32'h1234_5000);
    chk("R2 end", lk_end, 32'h1234_5FFF);
    look_hit("R1 inclusive end", 32'h1234_5FFF, 0, 1'b0, 32'hABCD_E000);
    look_miss("R1 next page", 32'h1234_6000);
    look_miss("R1 prev page", 32'h1234_4FFF);
  endtask

  task automatic t_ins_prot();
    cmd(0, 0, 0, 1, 32'h1234_5ABC, 32'hFABC_DEF7);
    look_hit("R5 valid", 32'h1234_5000, 0, 1'b1, 32'hABCD_E000);
    chk("R5 fields", lk_prot, 32'h3ABC_DEF6);
    chk("R6 no err on hit", {31'd0, seq_err}, 32'd0);
  endtask

  task automatic t_seq_err();
    cmd(0, 0, 0, 1, 32'h5555_5000, 32'h1000_0000);
    chk("R6 err pulse", {31'd0, seq_err}, 32'd1);
    look_miss("R6 no new slot", 32'h5555_5000);
    look_hit("R6 slot kept", 32'h1234_5000, 0, 1'b1, 32'hABCD_E000);
    chk("R6 prot kept", lk_prot, 32'h3ABC_DEF6);
    @(negedge clk);
    chk("R6 one cycle", {31'd0, seq_err}, 32'd0);
  endtask

  task automatic t_reuse();
    cmd(0, 0, 1, 0, 32'h1234_5000, 32'h0022_2220);
    look_hit("R3 reuse slot", 32'h1234_5800, 0, 1'b0, 32'h1111_1000);
    chk("R3 flushed prot", lk_prot, 32'h0);
    cmd(0, 0, 1, 0, 32'h2000_0000, 32'h0);
    look_hit("R3 pointer held", 32'h2000_0000, 1, 1'b0, 32'h0);
  endtask

  task automatic t_wrap();
    for (int k = 0; k < 14; k++) cmd(0, 0, 1, 0, 32'h3000_0000 + k * 32'h1000, 32'h0);
    look_hit("R4 last slot", 32'h3000_D000, 15, 1'b0, 32'h0);
    cmd(0, 0, 1, 0, 32'h4000_0000, 32'h0000_0840);
    look_hit("R4 wrap to 0", 32'h4000_0000, 0, 1'b0, 32'h0004_2000);
    look_miss("R4 evicted", 32'h1234_5000);
    look_hit("R4 survivor", 32'h2000_0FFF, 1, 1'b0, 32'h0);
  endtask

  task automatic t_purge_one();
    cmd(0, 0, 0, 1, 32'h4000_0010, 32'h1000_0000);
    look_hit("R5 dirty only", 32'h4000_0000, 0, 1'b1, 32'h0004_2000);
    chk("R5 dirty word", lk_prot, 32'h1000_0000);
    cmd(0, 1, 0, 0, 32'h4000_0800, 32'h0);
    look_miss("R8 valid purged", 32'h4000_0000);
    look_miss("R7 top after flush", 32'hFFFF_FFFF);
    cmd(0, 1, 0, 0, 32'h3000_D123, 32'h0);
    look_hit("R8 invalid kept", 32'h3000_D000, 15, 1'b0, 32'h0);
  endtask

  task automatic t_priority();
    cmd(0, 0, 1, 1, 32'h3000_C000, 32'h0157_9BC0);
    look_hit("R11 addr over prot", 32'h3000_C000, 14, 1'b0, 32'hABCD_E000);
    cmd(0, 1, 1, 0, 32'h7000_0000, 32'h0);
    look_miss("R11 purge over addr", 32'h7000_0000);
    cmd(1, 0, 1, 0, 32'h5000_0000, 32'h0);
    look_miss("R11 purge-all over addr", 32'h5000_0000);
    look_miss("R9 slot 15 gone", 32'h3000_D000);
    look_miss("R9 slot 1 gone", 32'h2000_0000);
    look_miss("R7 zero after purge", 32'h0);
    cmd(0, 0, 1, 0, 32'h6000_0000, 32'h0);
    look_hit("R9 pointer kept", 32'h6000_0000, 1, 1'b0, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ins_addr();
    t_ins_prot();
    t_seq_err();
    t_reuse();
    t_wrap();
    t_purge_one();
    t_priority();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule